// File: doc/BRIEF.md
# UART Line Status Tracker

This block keeps the eight-bit line status byte of a 16550-style UART. A receiver front end hands it received characters together with three error tags: parity, framing and break. The block stores each character with its tags in a receive queue. The queue is 16 deep in FIFO mode and holds a single entry in non-FIFO mode. The tags of the character at the head of the queue drive the per-character error bits. A summary bit reports any errored character still held. The transmit side supplies two occupancy levels, and the block turns them into the two transmitter bits.

Software reads the status byte before it reads the receive buffer, so that the status describes the character about to be popped.

The receive side offers no back-pressure. `rx_valid` is a one-cycle push strobe that is never refused. A character that arrives while the queue is full is dropped, and the overrun bit records it.

`lsr_rd` and `rbr_rd` are one-cycle read strobes. `fifo_en` may change only while the queue is empty. All other pins are plain levels.

Top module: `uart_lsr_track`

## Requirements
- R1: Reset drives `lsr` to 0x60 whatever the transmit inputs are, and `rbr_data` to 0.
- R2: Bit 0 (data ready) is 1 whenever at least one character is stored, and returns to 0 after the last one is popped by `rbr_rd`. While it is 1, `rbr_data` shows the oldest stored character, characters leave in arrival order, and while it is 0, `rbr_data` is 0.
- R3: Capacity is 16 characters with `fifo_en`=1 and 1 character with `fifo_en`=0. A push that finds the queue full discards the character (even if a pop happens in the same cycle) and sets bit 1 (overrun). A status read clears bit 1, and a new overrun in the same cycle wins over the clear.
- R4: Bits 4, 3 and 2 (break, framing, parity) are loaded with the tags of a character when it becomes the head: a push into an empty queue, or a pop that leaves a next character. They keep their value after that character is popped, until a status read clears them. A head load in the same cycle as a status read wins.
- R5: Bit 7 (receive error summary) is 1 while any stored character has a nonzero tag. After the last such character leaves, it stays 1 until a status read happens while no errored character remains. It reads 0 with `fifo_en`=0.
- R6: Bit 5 equals `thr_empty` and bit 6 equals `thr_empty` AND `tsr_empty`, both as sampled at the previous clock edge.
- R7: An `rbr_rd` with the queue empty leaves `lsr` and `rbr_data` unchanged.
- R8: A status read changes neither bit 0 nor `rbr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | 1 selects 16-deep queue, 0 single buffer |
| rx_valid | input | 1 | Push strobe for a received character |
| rx_data | input | 8 | Received character |
| rx_pe | input | 1 | Parity error tag of the character |
| rx_fe | input | 1 | Framing error tag of the character |
| rx_brk | input | 1 | Break tag of the character |
| thr_empty | input | 1 | Holding register (or transmit FIFO) empty |
| tsr_empty | input | 1 | Transmit shift register empty |
| lsr_rd | input | 1 | Status byte read strobe |
| rbr_rd | input | 1 | Receive buffer read strobe (pop) |
| lsr | output | 8 | Status byte |
| rbr_data | output | 8 | Character at the head of the queue |

## Verification
Every result is due one clock edge after the strobe or level that causes it. A push, pop or status read sampled at edge N shows up in `lsr` and `rbr_data` just after edge N, and so do the transmit bits, taken from the inputs sampled at N. The bench drives each cycle's inputs 1 ns after an edge, lets the next edge take them, and compares every field 1 ns after that edge against a model updated for the same edge. A sample therefore never lands on an edge and never lags a cycle.

// File: rtl/uart_lsr_pkg.sv
`timescale 1ns/1ps
package uart_lsr_pkg;
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic brk;
    logic fe;
    logic pe;
  } rx_tag_t;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    rx_tag_t           tag;
  } rx_entry_t;
endpackage

// File: rtl/lsr_rx_fifo.sv
`timescale 1ns/1ps
module lsr_rx_fifo
  import uart_lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fifo_en,
  input  logic      push_req,
  input  rx_entry_t wr_entry,
  input  logic      pop_req,
  output logic      overflow,
  output rx_entry_t head,
  output logic [CW-1:0] level,
  output logic [CW-1:0] err_level,
  output logic [CW-1:0] err_next,
  output logic      head_load,
  output rx_tag_t   next_head_tag
);
  rx_entry_t mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr, rd_nxt, wr_nxt;
  logic [CW-1:0] cap, level_next;
  logic full, accept, pop_ok, err_in, err_out;

  assign cap      = fifo_en ? CW'(DEPTH) : CW'(1);
  assign full     = (level >= cap);
  assign accept   = push_req && !full;
  assign overflow = push_req && full;
  assign pop_ok   = pop_req && (level != '0);
  assign rd_nxt   = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
  assign wr_nxt   = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
  assign head     = mem[rd_ptr];
  assign err_in   = accept && (|wr_entry.tag);
  assign err_out  = pop_ok && (|head.tag);

  always_comb begin
    level_next = level;
    if (accept && !pop_ok) level_next = level + 1'b1;
    else if (!accept && pop_ok) level_next = level - 1'b1;
    err_next = err_level;
    if (err_in && !err_out) err_next = err_level + 1'b1;
    else if (!err_in && err_out) err_next = err_level - 1'b1;
  end

  always_comb begin
    head_load     = 1'b0;
    next_head_tag = '0;
    if (pop_ok) begin
      if (level >= CW'(2)) begin
        head_load     = 1'b1;
        next_head_tag = mem[rd_nxt].tag;
      end else if (accept) begin
        head_load     = 1'b1;
        next_head_tag = wr_entry.tag;
      end
    end else if ((level == '0) && accept) begin
      head_load     = 1'b1;
      next_head_tag = wr_entry.tag;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr    <= '0;
      wr_ptr    <= '0;
      level     <= '0;
      err_level <= '0;
    end else begin
      if (accept) wr_ptr <= wr_nxt;
      if (pop_ok) rd_ptr <= rd_nxt;
      level     <= level_next;
      err_level <= err_next;
    end
  end

  // R3
  level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level <= CW'(DEPTH)) && (fifo_en || (level <= CW'(1))));

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && (level == '0) && !push_req) |=> (level == '0));

  // R5
  err_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_level <= level);
endmodule

// File: rtl/lsr_err_flags.sv
`timescale 1ns/1ps
module lsr_err_flags
  import uart_lsr_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          head_load,
  input  rx_tag_t       next_head_tag,
  input  logic          overflow,
  input  logic          status_rd,
  input  logic [CW-1:0] err_next,
  output rx_tag_t       head_flags,
  output logic          oe,
  output logic          rfe
);
  logic rfe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_flags <= '0;
      oe         <= 1'b0;
      rfe_q      <= 1'b0;
    end else begin
      if (head_load) head_flags <= next_head_tag;
      else if (status_rd) head_flags <= '0;

      if (overflow) oe <= 1'b1;
      else if (status_rd) oe <= 1'b0;

      if (err_next != '0) rfe_q <= 1'b1;
      else if (status_rd) rfe_q <= 1'b0;
    end
  end

  assign rfe = fifo_en & rfe_q;

  // R4
  tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!head_load && !status_rd) |=> $stable(head_flags));

  // R3
  oe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> oe);

  // R4
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !head_load) |=> (head_flags == '0));
endmodule

// File: rtl/lsr_tx_flags.sv
`timescale 1ns/1ps
module lsr_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_empty,
  input  logic tsr_empty,
  output logic thre,
  output logic temt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thre <= 1'b1;
      temt <= 1'b1;
    end else begin
      thre <= thr_empty;
      temt <= thr_empty & tsr_empty;
    end
  end
endmodule

// File: rtl/uart_lsr_track.sv
`timescale 1ns/1ps
module uart_lsr_track
  import uart_lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              rx_pe,
  input  logic              rx_fe,
  input  logic              rx_brk,
  input  logic              thr_empty,
  input  logic              tsr_empty,
  input  logic              lsr_rd,
  input  logic              rbr_rd,
  output logic [7:0]        lsr,
  output logic [CHAR_W-1:0] rbr_data
);
  rx_entry_t     wr_entry, head;
  rx_tag_t       next_head_tag, head_flags;
  logic [CW-1:0] level, err_level, err_next;
  logic          overflow, head_load, oe, rfe, thre, temt, dr;

  always_comb begin
    wr_entry.data    = rx_data;
    wr_entry.tag.brk = rx_brk;
    wr_entry.tag.fe  = rx_fe;
    wr_entry.tag.pe  = rx_pe;
  end

  lsr_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
    .push_req(rx_valid), .wr_entry(wr_entry), .pop_req(rbr_rd),
    .overflow(overflow), .head(head), .level(level),
    .err_level(err_level), .err_next(err_next),
    .head_load(head_load), .next_head_tag(next_head_tag)
  );

  lsr_err_flags #(.CW(CW)) u_err (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
    .head_load(head_load), .next_head_tag(next_head_tag),
    .overflow(overflow), .status_rd(lsr_rd), .err_next(err_next),
    .head_flags(head_flags), .oe(oe), .rfe(rfe)
  );

  lsr_tx_flags u_tx (
    .clk(clk), .rst_n(rst_n), .thr_empty(thr_empty), .tsr_empty(tsr_empty),
    .thre(thre), .temt(temt)
  );

  assign dr       = (level != '0);
  assign lsr      = {rfe, temt, thre, head_flags.brk, head_flags.fe,
                     head_flags.pe, oe, dr};
  assign rbr_data = dr ? head.data : '0;

  // R2
  dr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rbr_rd && (level == CW'(1)) && !rx_valid) |=> !lsr[0]);

  // R5
  rfe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && (err_level != '0)) |-> lsr[7]);

  // R2
  empty_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lsr[0] |-> (rbr_data == '0));

  // R8
  rd_keeps_dr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !rbr_rd && !rx_valid) |=> $stable(lsr[0]) && $stable(rbr_data));
endmodule

// File: tb/test_uart_lsr_track.sv
`timescale 1ns/1ps
module test_uart_lsr_track;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b1;
  logic rx_valid = 1'b0, rx_pe = 1'b0, rx_fe = 1'b0, rx_brk = 1'b0;
  logic [7:0] rx_data = '0;
  logic thr_empty = 1'b0, tsr_empty = 1'b0;
  logic lsr_rd = 1'b0, rbr_rd = 1'b0;
  logic [7:0] lsr, rbr_data;

  int total = 0, bad = 0;
  bit done = 0;

  logic [10:0] mq[$];
  logic [2:0]  m_flags = '0;
  bit m_oe = 0, m_rfe = 0, m_thre = 1, m_temt = 1, m_fen = 1;
  logic [15:0] lf = 16'hACE1;

  always #2.5 clk = ~clk;

  uart_lsr_track i_uart_lsr_track (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_pe(rx_pe), .rx_fe(rx_fe), .rx_brk(rx_brk),
    .thr_empty(thr_empty), .tsr_empty(tsr_empty), .lsr_rd(lsr_rd),
    .rbr_rd(rbr_rd), .lsr(lsr), .rbr_data(rbr_data)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 data ready", {31'd0, lsr[0]}, {31'd0, mq.size() > 0});
    chk("R2 head data", {24'd0, rbr_data}, (mq.size() > 0) ? {24'd0, mq[0][10:3]} : 32'd0);
    chk("R3 overrun", {31'd0, lsr[1]}, {31'd0, m_oe});
    chk("R4 head flags", {29'd0, lsr[4:2]}, {29'd0, m_flags});
    chk("R5 error summary", {31'd0, lsr[7]}, {31'd0, m_fen & m_rfe});
    chk("R6 tx bits", {30'd0, lsr[6:5]}, {30'd0, m_temt, m_thre});
  endtask

  task automatic step(input bit push, input logic [7:0] d, input logic [2:0] tg,
                      input bit pop, input bit rd);
    int sz, cap, errs;
    bit full, acc, popok, nh;
    logic [2:0] nt;
    rx_valid = push; rx_data = d; {rx_brk, rx_fe, rx_pe} = tg;
    rbr_rd = pop; lsr_rd = rd;
    @(posedge clk);
    #1;
    sz = mq.size();
    cap = m_fen ? 16 : 1;
    full = (sz >= cap);
    acc = push && !full;
    popok = pop && (sz > 0);
    nh = 0; nt = '0;
    if (popok) begin
      if (sz >= 2) begin nh = 1; nt = mq[1][2:0]; end
      else if (acc) begin nh = 1; nt = tg; end
    end else if (sz == 0 && acc) begin
      nh = 1; nt = tg;
    end
    if (popok) void'(mq.pop_front());
    if (acc) mq.push_back({d, tg});
    errs = 0;
    foreach (mq[k]) if (mq[k][2:0] != 3'd0) errs++;
    if (nh) m_flags = nt; else if (rd) m_flags = '0;
    if (push && full) m_oe = 1; else if (rd) m_oe = 0;
    if (errs > 0) m_rfe = 1; else if (rd) m_rfe = 0;
    m_thre = thr_empty;
    m_temt = thr_empty & tsr_empty;
    rx_valid = 0; rbr_rd = 0; lsr_rd = 0;
    check_all();
  endtask

  task automatic drain();
    while (mq.size() > 0) step(0, 8'h00, 3'd0, 1, 1);
    step(0, 8'h00, 3'd0, 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog got=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] sv_lsr, sv_data;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset value independent of transmit inputs (both held 0 here)
    chk("R1 reset lsr", {24'd0, lsr}, 32'h60);
    chk("R1 reset data", {24'd0, rbr_data}, 32'h0);
    rst_n = 1'b1;
    thr_empty = 1'b1; tsr_empty = 1'b1;
    step(0, 8'h00, 3'd0, 0, 0);

    // R6: sweep of transmit occupancy
    for (int t = 0; t < 4; t++) begin
      thr_empty = t[0]; tsr_empty = t[1];
      step(0, 8'h00, 3'd0, 0, 0);
    end
    thr_empty = 1'b1; tsr_empty = 1'b1;

    // R3/R4/R5: fill FIFO with every tag value, then overrun
    for (int i = 0; i < 16; i++) step(1, 8'(i * 17 + 3), 3'(i % 8), 0, 0);
    step(1, 8'hEE, 3'd7, 0, 0);
    step(1, 8'hEF, 3'd0, 1, 0);
    step(0, 8'h00, 3'd0, 0, 1);
    // pop all: read status, then pop
    while (mq.size() > 0) begin
      step(0, 8'h00, 3'd0, 0, 1);
      step(0, 8'h00, 3'd0, 1, 0);
    end
    step(0, 8'h00, 3'd0, 0, 0);
    step(0, 8'h00, 3'd0, 0, 1);

    // R7: pop on empty changes nothing
    step(1, 8'h5A, 3'd2, 0, 0);
    step(0, 8'h00, 3'd0, 1, 0);
    sv_lsr = lsr; sv_data = rbr_data;
    step(0, 8'h00, 3'd0, 1, 0);
    chk("R7 empty pop lsr", {24'd0, lsr}, {24'd0, sv_lsr});
    chk("R7 empty pop data", {24'd0, rbr_data}, {24'd0, sv_data});
    drain();

    // R8: status read keeps data ready and head
    step(1, 8'hC3, 3'd1, 0, 0);
    sv_data = rbr_data;
    step(0, 8'h00, 3'd0, 0, 1);
    chk("R8 read keeps dr", {31'd0, lsr[0]}, 32'd1);
    chk("R8 read keeps data", {24'd0, rbr_data}, {24'd0, sv_data});
    // R4: head load wins over simultaneous status read
    step(1, 8'h11, 3'd4, 0, 0);
    step(0, 8'h00, 3'd0, 1, 1);
    chk("R4 load beats read", {29'd0, lsr[4:2]}, 32'd4);
    drain();

    // random mix in FIFO mode, alternating fill-heavy and drain-heavy
    for (int c = 0; c < 3000; c++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      thr_empty = lf[9]; tsr_empty = lf[10];
      if (c[8]) step(lf[0] | lf[1], lf[15:8], lf[6:4], lf[2] & lf[3], lf[7] & lf[11]);
      else      step(lf[0] & lf[1], lf[15:8], lf[6:4], lf[2] | lf[3], lf[7] & lf[11]);
    end
    thr_empty = 1'b1; tsr_empty = 1'b1;
    drain();

    // non-FIFO mode: single buffer, every tag
    fifo_en = 1'b0; m_fen = 0;
    for (int g = 0; g < 8; g++) begin
      step(1, 8'(8'h80 + g), 3'(g), 0, 0);
      step(1, 8'h7F, 3'd0, 0, 0);
      step(1, 8'h7E, 3'd0, 1, 0);
      step(0, 8'h00, 3'd0, 0, 1);
      step(0, 8'h00, 3'd0, 1, 0);
    end
    for (int c = 0; c < 800; c++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0], lf[15:8], lf[6:4], lf[2], lf[7] & lf[3]);
    end
    drain();

    // back to FIFO mode: push and pop together at depth one
    fifo_en = 1'b1; m_fen = 1;
    step(1, 8'h21, 3'd0, 0, 0);
    step(1, 8'h22, 3'd3, 1, 0);
    step(1, 8'h23, 3'd0, 1, 1);
    drain();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule